// File: doc/BRIEF.md
# Self-Starting Five-Code Sequence Counter

This block is a three-bit synchronous counter that walks a fixed loop of five codes in a non-binary order: 000, 001, 011, 101, 110, then back to 000. It has no data inputs. It advances once on every rising clock edge unless the synchronous reset is high. The three state bits are the output. A wrap flag marks the last code of the loop.

Only five of the eight three-bit codes belong to the loop. The other three (010, 100, 111) each have a designed next code inside the loop. An upset or a power-up value can therefore never trap the counter in a side loop, and it rejoins the main sequence after one clock.

The reset code is a parameter. Its default is 000, which is the normal start of the loop. It can be set to any code, including the unused ones, so that the recovery path can be started on purpose.

Top module: `seq5_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes the parameter RESET_CODE (default 3'b000) on that edge.
- R2: With `rst` low, each rising edge moves the state along the loop 000→001→011→101→110→000.
- R3: `wrap` is 1 exactly while the state is 3'b110. The edge after `wrap` is seen with `rst` low yields 3'b000.
- R4: With `rst` low, unused code 3'b010 is followed by 3'b011.
- R5: With `rst` low, unused code 3'b100 is followed by 3'b000.
- R6: With `rst` low, unused code 3'b111 is followed by 3'b000.
- R7: From any code, the state is inside the five-code loop no more than two edges after reset is released. No code leads to a loop outside the main cycle.
- R8: With `rst` low, every rising edge changes the state; no code maps to itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, loads RESET_CODE |
| state | output | 3 | Present counter code |
| wrap | output | 1 | High while the state is the final loop code 110 |

## Verification
The bench builds four copies of the counter, with RESET_CODE set to 000, 010, 100 and 111. The three non-default values place each unused code in the register directly after reset. This exercises every recovery path through the ports alone, because the block has no load input. Random reset pulses break the default copy's loop at every phase. They also repeat the recovery from each unused code many times, while the loop position, the wrap flag and the entry delay are compared with a model in the bench.

// File: rtl/seq5_pkg.sv
package seq5_pkg;

    localparam int CODE_W   = 3;
    localparam int LOOP_LEN = 5;

    typedef enum logic [CODE_W-1:0] {
        C_START = 3'b000,
        C_ONE   = 3'b001,
        C_TWO   = 3'b011,
        C_THREE = 3'b101,
        C_LAST  = 3'b110,
        X_LOW   = 3'b010,
        X_HIGH  = 3'b100,
        X_ALL   = 3'b111
    } code_e;

    typedef struct packed {
        code_e code;
        logic  wrap;
    } view_t;

    function automatic code_e step_code(code_e cur);
        code_e n;
        case (cur)
            C_START: n = C_ONE;
            C_ONE:   n = C_TWO;
            C_TWO:   n = C_THREE;
            C_THREE: n = C_LAST;
            C_LAST:  n = C_START;
            X_LOW:   n = C_TWO;
            X_HIGH:  n = C_START;
            X_ALL:   n = C_START;
            default: n = C_START;
        endcase
        return n;
    endfunction

    function automatic logic on_loop(logic [CODE_W-1:0] c);
        return (c == 3'b000) || (c == 3'b001) || (c == 3'b011) ||
               (c == 3'b101) || (c == 3'b110);
    endfunction

endpackage

// File: rtl/seq5_step.sv
module seq5_step
    import seq5_pkg::*;
(
    input  code_e cur,
    output code_e nxt
);
    always_comb nxt = step_code(cur);

    // R8
    always_comb begin
        no_fixed_point_chk: assert (nxt != cur || $isunknown(cur));
    end
endmodule

// File: rtl/seq5_reg.sv
module seq5_reg
    import seq5_pkg::*;
#(
    parameter logic [CODE_W-1:0] RESET_CODE = 3'b000
) (
    input  logic  clk,
    input  logic  rst,
    input  code_e d,
    output code_e q
);
    localparam code_e INIT = code_e'(RESET_CODE);

    always_ff @(posedge clk) begin
        if (rst) q <= INIT;
        else     q <= d;
    end

    // R1
    reset_load_chk: assert property (@(posedge clk) rst |=> (q == INIT));
endmodule

// File: rtl/seq5_flag.sv
module seq5_flag
    import seq5_pkg::*;
(
    input  code_e cur,
    output view_t view
);
    always_comb begin
        view.code = cur;
        view.wrap = (cur == C_LAST);
    end
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
    import seq5_pkg::*;
#(
    parameter logic [2:0] RESET_CODE = 3'b000
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] state,
    output logic       wrap
);
    code_e cur_q;
    code_e nxt_c;
    view_t view_c;

    seq5_step u_step (.cur(cur_q), .nxt(nxt_c));

    seq5_reg #(.RESET_CODE(RESET_CODE)) u_reg (
        .clk(clk), .rst(rst), .d(nxt_c), .q(cur_q)
    );

    seq5_flag u_flag (.cur(cur_q), .view(view_c));

    assign state = view_c.code;
    assign wrap  = view_c.wrap;

    // R2
    loop_order_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b101) |=> (state == 3'b110));
    // R3
    wrap_to_start_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (state == 3'b000));
    // R3
    wrap_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wrap) |-> ($past(state) == 3'b101));
    // R4
    low_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b010) |=> (state == 3'b011));
    // R5
    high_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b100) |=> (state == 3'b000));
    // R6
    all_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b111) |=> (state == 3'b000));
    // R7
    rejoin_chk: assert property (@(posedge clk) disable iff (rst)
        !on_loop(state) |=> on_loop(state));
    // R8
    always_moves_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (state != $past(state)));
endmodule

// File: tb/test_seq5_counter.sv
module test_seq5_counter;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_DUT      = 4;
    localparam int  MAX_CYC    = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] st [N_DUT];
    logic       wr [N_DUT];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq5_counter #(.RESET_CODE(3'b000)) i_seq5_counter (
        .clk(clk), .rst(rst), .state(st[0]), .wrap(wr[0]));
    seq5_counter #(.RESET_CODE(3'b010)) i_seq5_counter_x2 (
        .clk(clk), .rst(rst), .state(st[1]), .wrap(wr[1]));
    seq5_counter #(.RESET_CODE(3'b100)) i_seq5_counter_x4 (
        .clk(clk), .rst(rst), .state(st[2]), .wrap(wr[2]));
    seq5_counter #(.RESET_CODE(3'b111)) i_seq5_counter_x7 (
        .clk(clk), .rst(rst), .state(st[3]), .wrap(wr[3]));

    function automatic logic [2:0] start_of(int i);
        case (i)
            0: return 3'b000;
            1: return 3'b010;
            2: return 3'b100;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [2:0] model_next(logic [2:0] c);
        if (c == 3'b110) return 3'b000;
        if (c == 3'b000) return 3'b001;
        if (c == 3'b001) return 3'b011;
        if (c == 3'b011) return 3'b101;
        if (c == 3'b101) return 3'b110;
        if (c == 3'b010) return 3'b011;
        return 3'b000;
    endfunction

    function automatic bit in_main(logic [2:0] c);
        return c == 3'b000 || c == 3'b001 || c == 3'b011 ||
               c == 3'b101 || c == 3'b110;
    endfunction

    task automatic check(string tag, int i, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s dut%0d actual=%0d expected=%0d at %0t", tag, i, act, exp, $time);
        end
    endtask

    logic [2:0] exp_st  [N_DUT];
    logic [2:0] prev_st [N_DUT];
    int         off_cnt [N_DUT];
    bit         last_rst;

    // Drive rst for one cycle at a falling edge, then check at the next falling edge.
    task automatic cycle(bit r);
        rst = r;
        last_rst = r;
        @(negedge clk);
        for (int i = 0; i < N_DUT; i++) begin
            logic [2:0] old;
            string tag;
            old = exp_st[i];
            if (last_rst) begin
                exp_st[i] = start_of(i);
                off_cnt[i] = 0;
                tag = "R1";
            end else begin
                exp_st[i] = model_next(old);
                if (old == 3'b010)      tag = "R4";
                else if (old == 3'b100) tag = "R5";
                else if (old == 3'b111) tag = "R6";
                else                    tag = "R2";
                checks++;
                if (st[i] == prev_st[i]) begin
                    failures++;
                    $display("FAIL R8 dut%0d actual=%0d expected=not %0d", i, st[i], prev_st[i]);
                end
                if (!in_main(st[i])) off_cnt[i]++;
                check("R7", i, int'(off_cnt[i] > 2), 0);
            end
            check(tag, i, int'(st[i]), int'(exp_st[i]));
            check("R3", i, int'(wr[i]), int'(exp_st[i] == 3'b110));
            prev_st[i] = st[i];
        end
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd5150);
        for (int i = 0; i < N_DUT; i++) begin
            exp_st[i] = 3'b000; prev_st[i] = 3'b000; off_cnt[i] = 0;
        end
        rst = 1'b1;
        @(negedge clk);
        // directed: reset held over several edges (R1)
        repeat (3) cycle(1'b1);
        // directed: two full loops with wrap (R2, R3), recovery paths (R4 R5 R6)
        repeat (12) cycle(1'b0);
        // directed: reset at each loop phase
        for (int k = 0; k < 5; k++) begin
            repeat (k + 1) cycle(1'b0);
            cycle(1'b1);
        end
        // constrained random reset pulses
        for (int n = 0; n < 3000; n++) begin
            cycle(($urandom % 7) == 0);
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < MAX_CYC; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule